// File: doc/BRIEF.md
# Three-Point Stencil Compute Process

This block is one compute process of a dataflow network that evaluates a one-dimensional three-point stencil over several time steps. An internal control counter walks the iteration pairs (t, i). Each iteration adds three values of the previous time step: the neighbours at positions i-1, i and i+1. A per-operand input selector decides, from the current iteration, whether each operand comes from the incoming load stream or from one of three internal local channels. An output router then sends the sum either into the local channels, where the next time step picks it up, or out through the store stream once the final time step is reached.

The load stream carries only the values that enter from outside: the whole initial row, plus the fixed boundary cells that are needed at later steps. Values inside the band travel through three in-order FIFO channels held inside the block, one for each operand position. The block is used by feeding the load items in iteration order and draining the store stream. A done pulse marks the end of the run.

Top module: `stencil_proc`

## Requirements
- R1: Iterations run with t from 1 to T_STEPS as the outer index and i from 1 to N_PTS as the inner index. Store items leave in ascending i order.
- R2: Each result equals left + centre + right, taken modulo 2^DW, where the operands are the step t-1 values at positions i-1, i and i+1.
- R3: The left operand comes from the load stream when t = 1 or i = 1. The centre operand comes from it when t = 1. The right operand comes from it when t = 1 or i = N_PTS. In every other case an operand is read from its local channel. When both sources would apply, the load source wins.
- R4: Within one iteration, the load-sourced operands consume consecutive load items in the order left, centre, right. Iterations consume items in iteration order.
- R5: Results with t < T_STEPS are never placed on the store stream. Exactly N_PTS store items, those of step T_STEPS, appear per run.
- R6: While st_valid_o is high and st_ready_i is low, st_valid_o stays high and st_data_o stays unchanged.
- R7: The iteration counter holds whenever a selected operand is missing or the targeted output cannot accept a result. Gaps on either stream lose or duplicate no result.
- R8: During and right after reset, st_valid_o and done_o are low and ld_ready_o is high.
- R9: done_o is high for exactly one cycle, the cycle after the handshake of the last store item. After that, further load items produce no store output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid_i | input | 1 | Load item valid |
| ld_data_i | input | DW | Load item value |
| ld_ready_o | output | 1 | Load queue can accept an item |
| st_valid_o | output | 1 | Store item valid (registered) |
| st_data_o | output | DW | Store item value (registered) |
| st_ready_i | input | 1 | Store consumer accepts the item |
| done_o | output | 1 | One-cycle pulse after the final store handshake |

## Verification
A load item offered while ld_ready_o is high enters the queue at the next rising edge. The earliest iteration that can use it fires on that same edge's following cycle. A final-step result shows up on st_valid_o one clock after its iteration fires, and done_o rises one clock after the last store handshake. The bench drives and samples only on falling edges. It predicts each handshake for the coming rising edge from values that are already stable, and it expects done_o exactly one falling edge after the final predicted handshake. Since intermediate timing depends on the stall pattern, store data are checked by order through the scoreboard rather than by a fixed cycle. The hold rule and the done pulse are checked against exact cycles.

// File: rtl/stencil_pkg.sv
package stencil_pkg;
  localparam int NUM_OPS = 3;
  localparam int OP_LEFT  = 0;
  localparam int OP_MID   = 1;
  localparam int OP_RIGHT = 2;
endpackage

// File: rtl/stencil_iter_ctrl.sv
module stencil_iter_ctrl #(
  parameter int T_STEPS = 4,
  parameter int N_PTS   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic adv_i,
  output logic first_step_o,
  output logic last_step_o,
  output logic low_edge_o,
  output logic high_edge_o,
  output logic last_iter_o,
  output logic finished_o
);
  localparam int TW = $clog2(T_STEPS + 1);
  localparam int IW = $clog2(N_PTS + 1);

  logic [TW-1:0] t_q;
  logic [IW-1:0] i_q;
  logic          fin_q;

  assign first_step_o = (t_q == TW'(1));
  assign last_step_o  = (t_q == TW'(T_STEPS));
  assign low_edge_o   = (i_q == IW'(1));
  assign high_edge_o  = (i_q == IW'(N_PTS));
  assign last_iter_o  = last_step_o && high_edge_o;
  assign finished_o   = fin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      t_q   <= TW'(1);
      i_q   <= IW'(1);
      fin_q <= 1'b0;
    end else if (adv_i) begin
      if (high_edge_o) begin
        i_q <= IW'(1);
        if (last_step_o) fin_q <= 1'b1;
        else             t_q   <= t_q + TW'(1);
      end else begin
        i_q <= i_q + IW'(1);
      end
    end
  end

  // R1: inner index steps by one within a row
  a_r1_inner_step: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !high_edge_o) |=> (i_q == $past(i_q) + IW'(1)) && (t_q == $past(t_q)));
  // R1: row wrap moves to the next time step
  a_r1_row_wrap: assert property (@(posedge clk) disable iff (rst)
    (adv_i && high_edge_o && !last_step_o) |=> (i_q == IW'(1)) && (t_q == $past(t_q) + TW'(1)));
  // R7: counters hold while no iteration fires
  a_r7_hold_count: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(i_q) && $stable(t_q));
endmodule

// File: rtl/stencil_load_queue.sv
module stencil_load_queue #(
  parameter int DW     = 16,
  parameter int DEPTH  = 4,
  parameter int MAXPOP = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push_i,
  input  logic [DW-1:0]                push_data_i,
  input  logic [1:0]                   pop_n_i,
  output logic                         room_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic [MAXPOP-1:0][DW-1:0]    head_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] q   [DEPTH];
  logic [DW-1:0] q_nx[DEPTH];
  logic [CW-1:0] cnt_q;

  assign room_o  = (cnt_q < CW'(DEPTH));
  assign count_o = cnt_q;

  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      if (k + int'(pop_n_i) < DEPTH) q_nx[k] = q[k + int'(pop_n_i)];
      else                           q_nx[k] = q[k];
    end
    if (push_i) q_nx[int'(cnt_q) - int'(pop_n_i)] = push_data_i;
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < DEPTH; k++) q[k] <= q_nx[k];
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q - CW'(pop_n_i) + CW'(push_i);
  end

  for (genvar g = 0; g < MAXPOP; g++) begin : g_head
    assign head_o[g] = q[g];
  end

  // R4: never take more load items than are queued
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
    int'(pop_n_i) <= int'(cnt_q));
  // R7: never accept an item without room
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push_i |-> cnt_q < CW'(DEPTH));
endmodule

// File: rtl/stencil_chan_fifo.sv
module stencil_chan_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_i,
  output logic [DW-1:0] rd_data_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;

  assign full_o    = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o   = (cnt_q == '0);
  assign rd_data_o = mem[rp_q];

  always_ff @(posedge clk) begin
    if (wr_i) mem[wp_q] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_i) wp_q <= wp_q + AW'(1);
      if (rd_i) rp_q <= rp_q + AW'(1);
      cnt_q <= cnt_q + (AW+1)'(wr_i) - (AW+1)'(rd_i);
    end
  end

  // R5: a channel is never written when full
  a_r5_chan_no_overflow: assert property (@(posedge clk) disable iff (rst)
    wr_i |-> !full_o);
  // R3: a channel operand is only taken when present
  a_r3_chan_no_underflow: assert property (@(posedge clk) disable iff (rst)
    rd_i |-> !empty_o);
endmodule

// File: rtl/stencil_proc.sv
module stencil_proc #(
  parameter int T_STEPS  = 4,
  parameter int N_PTS    = 8,
  parameter int DW       = 16,
  parameter int LQ_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_valid_i,
  input  logic [DW-1:0] ld_data_i,
  output logic          ld_ready_o,
  output logic          st_valid_o,
  output logic [DW-1:0] st_data_o,
  input  logic          st_ready_i,
  output logic          done_o
);
  import stencil_pkg::*;

  localparam int CH_AW    = $clog2(N_PTS + 1);
  localparam int CH_DEPTH = 1 << CH_AW;
  localparam int LCW      = $clog2(LQ_DEPTH + 1);

  logic first_step, last_step, low_edge, high_edge, last_iter, finished;
  logic fire;

  stencil_iter_ctrl #(.T_STEPS(T_STEPS), .N_PTS(N_PTS)) u_ctrl (
    .clk(clk), .rst(rst), .adv_i(fire),
    .first_step_o(first_step), .last_step_o(last_step),
    .low_edge_o(low_edge), .high_edge_o(high_edge),
    .last_iter_o(last_iter), .finished_o(finished)
  );

  // operand source selection (load wins over channel)
  logic [NUM_OPS-1:0] from_load;
  logic [NUM_OPS-1:0] ch_wmask;
  assign from_load[OP_LEFT]  = first_step || low_edge;
  assign from_load[OP_MID]   = first_step;
  assign from_load[OP_RIGHT] = first_step || high_edge;

  // result targets in the next step: left feed skips i=N, right feed skips i=1
  assign ch_wmask[OP_LEFT]  = !high_edge;
  assign ch_wmask[OP_MID]   = 1'b1;
  assign ch_wmask[OP_RIGHT] = !low_edge;

  logic [1:0] need_cnt;
  assign need_cnt = 2'($countones(from_load));

  // load queue
  logic                      lq_room;
  logic [LCW-1:0]            lq_count;
  logic [NUM_OPS-1:0][DW-1:0] lq_head;
  logic [1:0]                lq_pop;

  assign ld_ready_o = lq_room;
  assign lq_pop     = fire ? need_cnt : 2'd0;

  stencil_load_queue #(.DW(DW), .DEPTH(LQ_DEPTH), .MAXPOP(NUM_OPS)) u_lq (
    .clk(clk), .rst(rst),
    .push_i(ld_valid_i && lq_room), .push_data_i(ld_data_i),
    .pop_n_i(lq_pop), .room_o(lq_room), .count_o(lq_count), .head_o(lq_head)
  );

  // local channels and operand multiplexers
  logic [NUM_OPS-1:0]         ch_full, ch_empty, ch_wr, ch_rd;
  logic [NUM_OPS-1:0][DW-1:0] ch_dout;
  logic [NUM_OPS-1:0][DW-1:0] opnd;
  logic [NUM_OPS-1:0][1:0]    lidx;
  logic [DW-1:0]              sum;

  always_comb begin
    lidx[OP_LEFT]  = 2'd0;
    lidx[OP_MID]   = {1'b0, from_load[OP_LEFT]};
    lidx[OP_RIGHT] = {1'b0, from_load[OP_LEFT]} + {1'b0, from_load[OP_MID]};
  end

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    assign ch_rd[g] = fire && !from_load[g];
    assign ch_wr[g] = fire && !last_step && ch_wmask[g];
    assign opnd[g]  = from_load[g] ? lq_head[lidx[g]] : ch_dout[g];

    stencil_chan_fifo #(.DW(DW), .DEPTH(CH_DEPTH)) u_ch (
      .clk(clk), .rst(rst),
      .wr_i(ch_wr[g]), .wr_data_i(sum),
      .rd_i(ch_rd[g]), .rd_data_o(ch_dout[g]),
      .full_o(ch_full[g]), .empty_o(ch_empty[g])
    );
  end

  assign sum = opnd[OP_LEFT] + opnd[OP_MID] + opnd[OP_RIGHT];

  // firing rule
  logic ops_ok, out_ok;
  assign ops_ok = (int'(need_cnt) <= int'(lq_count)) && (&(from_load | ~ch_empty));
  assign out_ok = last_step ? (!st_valid_o || st_ready_i) : (&(~ch_wmask | ~ch_full));
  assign fire   = !finished && ops_ok && out_ok;

  // store register and done pulse
  logic st_last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_valid_o <= 1'b0;
      st_data_o  <= '0;
      st_last_q  <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= st_valid_o && st_ready_i && st_last_q;
      if (fire && last_step) begin
        st_valid_o <= 1'b1;
        st_data_o  <= sum;
        st_last_q  <= last_iter;
      end else if (st_ready_i) begin
        st_valid_o <= 1'b0;
      end
    end
  end

  // R6: a pending store item is held until accepted
  a_r6_store_hold: assert property (@(posedge clk) disable iff (rst)
    (st_valid_o && !st_ready_i) |=> st_valid_o && $stable(st_data_o));
  // R5: a new store item comes only from a final-step iteration
  a_r5_store_source: assert property (@(posedge clk) disable iff (rst)
    $rose(st_valid_o) |-> $past(fire && last_step));
  // R9: done lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R3: a first-step iteration takes all three operands from the queue
  a_r3_first_row_loads: assert property (@(posedge clk) disable iff (rst)
    (fire && first_step) |-> int'(lq_count) >= NUM_OPS);
endmodule

// File: tb/stencil_proc_tb.sv
module stencil_proc_tb;
  localparam int TS = 4;
  localparam int NP = 8;
  localparam int DW = 16;
  localparam int LIMIT = 5000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst;
  logic          ld_valid;
  logic [DW-1:0] ld_data;
  logic          ld_ready;
  logic          st_valid;
  logic [DW-1:0] st_data;
  logic          st_ready;
  logic          done;

  stencil_proc #(.T_STEPS(TS), .N_PTS(NP), .DW(DW), .LQ_DEPTH(4)) u_dut (
    .clk(clk), .rst(rst),
    .ld_valid_i(ld_valid), .ld_data_i(ld_data), .ld_ready_o(ld_ready),
    .st_valid_o(st_valid), .st_data_o(st_data), .st_ready_i(st_ready),
    .done_o(done)
  );

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] ldq[$];
  logic [DW-1:0] expq[$];
  logic [DW-1:0] grid [0:TS][0:NP+1];
  bit run = 0;
  bit extra = 0;
  bit test_done = 0;
  bit done_due = 0;
  int done_cnt = 0;
  int mode = 0;
  bit prev_hold = 0;
  logic [DW-1:0] prev_data;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver side of the scoreboard: reference grid, load list, expected stores
  task automatic build(input int m);
    ldq.delete();
    expq.delete();
    for (int k = 0; k <= NP + 1; k++)
      grid[0][k] = (m == 2) ? 16'hFFFF - DW'(k) : DW'($urandom);
    for (int t = 1; t <= TS; t++) begin
      grid[t][0]    = grid[0][0];
      grid[t][NP+1] = grid[0][NP+1];
      for (int i = 1; i <= NP; i++)
        grid[t][i] = grid[t-1][i-1] + grid[t-1][i] + grid[t-1][i+1];
    end
    for (int t = 1; t <= TS; t++)
      for (int i = 1; i <= NP; i++) begin
        if (t == 1 || i == 1)  ldq.push_back(grid[t-1][i-1]);
        if (t == 1)            ldq.push_back(grid[t-1][i]);
        if (t == 1 || i == NP) ldq.push_back(grid[t-1][i+1]);
      end
    for (int i = 1; i <= NP; i++) expq.push_back(grid[TS][i]);
  endtask

  // load driver
  always @(negedge clk) begin
    if (run && extra) begin
      ld_valid = 1'b1;
      ld_data  = DW'($urandom);
    end else if (run && ldq.size() > 0) begin
      if (mode == 0 || ($urandom % 3) != 0) begin
        ld_valid = 1'b1;
        ld_data  = ldq[0];
        if (ld_ready) void'(ldq.pop_front());
      end else begin
        ld_valid = 1'b0;
      end
    end else begin
      ld_valid = 1'b0;
    end
  end

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (run) begin
      bit r;
      if (done_due) begin
        chk(done == 1'b1, "R9", "done one cycle after last store", int'(done), 1);
        done_due = 0;
        if (done) begin
          done_cnt++;
          test_done = 1;
        end
      end else if (done) begin
        done_cnt++;
        chk(1'b0, "R9", "unexpected done", 1, 0);
      end
      if (prev_hold)
        chk(st_valid && st_data == prev_data, "R6", "held store item", int'(st_data), int'(prev_data));
      r = (mode == 0) ? 1'b1 : 1'(($urandom % 2) != 0);
      st_ready = r;
      if (st_valid && r) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R5", "store item beyond N_PTS", int'(st_data), 0);
        end else begin
          logic [DW-1:0] e;
          e = expq.pop_front();
          chk(st_data == e, "R1 R2 R3 R4 R7", "store value", int'(st_data), int'(e));
          if (expq.size() == 0) done_due = 1;
        end
      end
      prev_hold = st_valid && !r;
      prev_data = st_data;
    end
  end

  task automatic run_test(input int m);
    int cyc;
    mode = m;
    run = 0;
    extra = 0;
    test_done = 0;
    done_due = 0;
    done_cnt = 0;
    prev_hold = 0;
    rst = 1'b1;
    ld_valid = 1'b0;
    st_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(!st_valid && !done && ld_ready, "R8", "outputs in reset",
        int'({st_valid, done, ld_ready}), 1);
    rst = 1'b0;
    @(negedge clk);
    chk(!st_valid && !done && ld_ready, "R8", "outputs after reset",
        int'({st_valid, done, ld_ready}), 1);
    build(m);
    run = 1;
    cyc = 0;
    while (!test_done && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
    end
    chk(test_done, "R9", "watchdog: run finished", cyc, LIMIT);
    chk(expq.size() == 0, "R5", "store items left unproduced", expq.size(), 0);
    extra = 1;
    repeat (20) @(negedge clk);
    chk(st_valid == 1'b0, "R9", "no output from loads after done", int'(st_valid), 0);
    chk(done_cnt == 1, "R9", "done pulse count", done_cnt, 1);
    extra = 0;
    run = 0;
  endtask

  initial begin
    rst = 1'b1;
    ld_valid = 1'b0;
    ld_data = '0;
    st_ready = 1'b0;
    run_test(0);
    run_test(1);
    run_test(2);
    run_test(1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule